// File: doc/BRIEF.md
# Vectored Interrupt Request Tracker

This block keeps the delivery state for 256 numbered interrupt vectors. Three 256-bit sets are held, one bit per vector: requests waiting for service, vectors currently being serviced, and an enable mask that filters incoming requests. Sources raise a vector by number. The processor side acknowledges the vector it takes, which moves it from waiting to in service. It signals end of interrupt when the handler finishes.

The block drives a pending flag and the vector number to deliver. Priority is numeric, so a larger vector number always wins. A request is offered only when it outranks everything already in service. A 32-bit register port shows each 256-bit set as eight words. Software can rewrite the enable words. The other two sets can only be read.

Top module: `vit_tracker`

## Requirements
- R1: After reset, every request and in-service bit reads 0, every enable bit reads 1, and `irq_pending` is low.
- R2: A raise of vector v with enable bit v set makes request bit v read 1 after the next clock edge.
- R3: A raise of a vector whose request bit is already set leaves the request set unchanged, so repeated raises collapse into one request.
- R4: A raise of a vector whose enable bit is 0 is dropped, and its request bit stays 0.
- R5: `irq_pending` is high only when some request bit is set and the highest set request index is strictly greater than the highest set in-service index. An empty in-service set counts as lower than vector 0.
- R6: While `irq_pending` is high, `irq_vector` gives the highest set request index. While it is low, `irq_vector` is 0.
- R7: An acknowledge of vector v sets in-service bit v and clears request bit v in the same clock edge.
- R8: An end-of-interrupt clears only the highest-numbered set in-service bit. With no in-service bit set, it changes nothing.
- R9: Word k (k = 0..7) of each set holds vectors 32k to 32k+31, with bit n standing for vector 32k+n. The words are read at 0x100 + 0x10·k for in-service, 0x200 + 0x10·k for request and 0x480 + 0x10·k for enable. `reg_rdata` is combinational from `reg_addr`. Unmapped addresses read 0.
- R10: A write to an enable word replaces that word after the clock edge. Writes to request or in-service addresses are ignored.
- R11: When a raise and an acknowledge of the same enabled vector occur in one cycle, the acknowledge applies first. After the edge the vector is both in service and requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raise_vld | input | 1 | Raise strobe |
| raise_vec | input | 8 | Vector being raised |
| ack_vld | input | 1 | Acknowledge strobe from the processor side |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_pending | output | 1 | A request outranks all in-service vectors |
| irq_vector | output | 8 | Vector to deliver, 0 when nothing is pending |

## Verification
The vectors under test are chosen to fall in different words and at different bit positions: 0, 5, 40, 70, 200 and 255. This exposes errors in word or bit placement in the register view, and ordering errors in both stages of the priority search. One sequence nests a high vector above a lower one already in service, then retires the two with back-to-back end-of-interrupts. The delivered vector after each retirement shows whether the highest or the lowest in-service bit was cleared. Further cases cover a raise that ties with the in-service vector, a raise of vector 0 with nothing in service, a raise of a disabled vector, a write to a read-only word, and a raise and an acknowledge of the same vector in one cycle. Each of these separates the strict comparison and the stated ordering from plausible wrong variants.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int VEC_W    = 8;
  localparam int NUM_VEC  = 1 << VEC_W;
  localparam int DATA_W   = 32;
  localparam int WORDS    = NUM_VEC / DATA_W;
  localparam int ADDR_W   = 12;
  localparam int SLOT_SH  = 4;
  // Register windows, given as 16-byte slot numbers.
  localparam int ISR_SLOT = 'h10;
  localparam int REQ_SLOT = 'h20;
  localparam int EN_SLOT  = 'h48;
endpackage

// File: rtl/vit_prio_enc.sv
// Highest-set-bit search in two stages: group select, then bit select.
module vit_prio_enc #(
  parameter int WIDTH = 256,
  parameter int GRP   = 8,
  localparam int NG   = WIDTH / GRP,
  localparam int GW   = $clog2(NG),
  localparam int BW   = $clog2(GRP)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             valid_o,
  output logic [GW+BW-1:0] idx_o
);
  logic [NG-1:0]  grp_any;
  logic [GW-1:0]  grp_sel;
  logic [GRP-1:0] grp_bits;
  logic [BW-1:0]  bit_sel;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |vec_i[g*GRP +: GRP];
  end

  always_comb begin
    grp_sel = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) grp_sel = g[GW-1:0];
    end
  end

  assign grp_bits = vec_i[grp_sel*GRP +: GRP];

  always_comb begin
    bit_sel = '0;
    for (int b = 0; b < GRP; b++) begin
      if (grp_bits[b]) bit_sel = b[BW-1:0];
    end
  end

  assign valid_o = |grp_any;
  assign idx_o   = {grp_sel, bit_sel};
endmodule

// File: rtl/vit_state.sv
// Request, in-service and enable registers with their update rules.
module vit_state #(
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32,
  localparam int NUM_VEC = 1 << VEC_W,
  localparam int WORDS   = NUM_VEC / DATA_W,
  localparam int WIX     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_vld,
  input  logic [VEC_W-1:0]   raise_vec,
  input  logic               ack_vld,
  input  logic [VEC_W-1:0]   ack_vec,
  input  logic               eoi,
  input  logic               isr_top_vld,
  input  logic [VEC_W-1:0]   isr_top_idx,
  input  logic               en_wr_vld,
  input  logic [WIX-1:0]     en_wr_word,
  input  logic [DATA_W-1:0]  en_wr_data,
  output logic [NUM_VEC-1:0] req_q,
  output logic [NUM_VEC-1:0] isr_q,
  output logic [NUM_VEC-1:0] en_q
);
  logic [NUM_VEC-1:0] req_d, isr_d, en_d;
  logic               upd_en;

  assign upd_en = raise_vld | ack_vld | eoi | en_wr_vld;

  always_comb begin
    req_d = req_q;
    isr_d = isr_q;
    en_d  = en_q;
    if (eoi && isr_top_vld) isr_d[isr_top_idx] = 1'b0;
    if (ack_vld) begin
      isr_d[ack_vec] = 1'b1;
      req_d[ack_vec] = 1'b0;
    end
    if (raise_vld && en_q[raise_vec]) req_d[raise_vec] = 1'b1;
    if (en_wr_vld) en_d[en_wr_word*DATA_W +: DATA_W] = en_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      isr_q <= '0;
      en_q  <= '1;
    end else if (upd_en) begin
      req_q <= req_d;
      isr_q <= isr_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/vit_regport.sv
// Word view of the three sets; only the enable window accepts writes.
module vit_regport #(
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  localparam int NUM_VEC = 1 << VEC_W,
  localparam int WORDS   = NUM_VEC / DATA_W,
  localparam int WIX     = $clog2(WORDS),
  localparam int SLOT_W  = ADDR_W - vit_pkg::SLOT_SH
) (
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] isr_i,
  input  logic [NUM_VEC-1:0] en_i,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               en_wr_vld,
  output logic [WIX-1:0]     en_wr_word,
  output logic [DATA_W-1:0]  en_wr_data
);
  localparam logic [SLOT_W-1:0] ISR_S = SLOT_W'(vit_pkg::ISR_SLOT);
  localparam logic [SLOT_W-1:0] REQ_S = SLOT_W'(vit_pkg::REQ_SLOT);
  localparam logic [SLOT_W-1:0] EN_S  = SLOT_W'(vit_pkg::EN_SLOT);
  localparam logic [SLOT_W-1:0] NW    = SLOT_W'(WORDS);

  logic [SLOT_W-1:0] slot, isr_off, req_off, en_off;
  logic              isr_hit, req_hit, en_hit;

  assign slot    = reg_addr[ADDR_W-1:vit_pkg::SLOT_SH];
  assign isr_off = slot - ISR_S;
  assign req_off = slot - REQ_S;
  assign en_off  = slot - EN_S;
  assign isr_hit = isr_off < NW;
  assign req_hit = req_off < NW;
  assign en_hit  = en_off < NW;

  always_comb begin
    reg_rdata = '0;
    if (isr_hit)      reg_rdata = isr_i[isr_off[WIX-1:0]*DATA_W +: DATA_W];
    else if (req_hit) reg_rdata = req_i[req_off[WIX-1:0]*DATA_W +: DATA_W];
    else if (en_hit)  reg_rdata = en_i[en_off[WIX-1:0]*DATA_W +: DATA_W];
  end

  assign en_wr_vld  = reg_wr & en_hit;
  assign en_wr_word = en_off[WIX-1:0];
  assign en_wr_data = reg_wdata;
endmodule

// File: rtl/vit_tracker.sv
module vit_tracker #(
  parameter int VEC_W  = vit_pkg::VEC_W,
  parameter int DATA_W = vit_pkg::DATA_W,
  parameter int ADDR_W = vit_pkg::ADDR_W,
  localparam int NUM_VEC = 1 << VEC_W,
  localparam int WORDS   = NUM_VEC / DATA_W,
  localparam int WIX     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_vld,
  input  logic [VEC_W-1:0]  raise_vec,
  input  logic              ack_vld,
  input  logic [VEC_W-1:0]  ack_vec,
  input  logic              eoi,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pending,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_VEC-1:0] req_q, isr_q, en_q;
  logic               req_vld, isr_vld, en_wr_vld;
  logic [VEC_W-1:0]   req_idx, isr_idx;
  logic [WIX-1:0]     en_wr_word;
  logic [DATA_W-1:0]  en_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  vit_state #(.VEC_W(VEC_W), .DATA_W(DATA_W)) state_i (
    .clk(clk), .rst_n(rst_sync_n),
    .raise_vld(raise_vld), .raise_vec(raise_vec),
    .ack_vld(ack_vld), .ack_vec(ack_vec), .eoi(eoi),
    .isr_top_vld(isr_vld), .isr_top_idx(isr_idx),
    .en_wr_vld(en_wr_vld), .en_wr_word(en_wr_word), .en_wr_data(en_wr_data),
    .req_q(req_q), .isr_q(isr_q), .en_q(en_q)
  );

  vit_prio_enc #(.WIDTH(NUM_VEC)) req_enc_i (
    .vec_i(req_q), .valid_o(req_vld), .idx_o(req_idx)
  );

  vit_prio_enc #(.WIDTH(NUM_VEC)) isr_enc_i (
    .vec_i(isr_q), .valid_o(isr_vld), .idx_o(isr_idx)
  );

  vit_regport #(.VEC_W(VEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .req_i(req_q), .isr_i(isr_q), .en_i(en_q),
    .reg_rdata(reg_rdata),
    .en_wr_vld(en_wr_vld), .en_wr_word(en_wr_word), .en_wr_data(en_wr_data)
  );

  assign irq_pending = req_vld && (!isr_vld || (req_idx > isr_idx));
  assign irq_vector  = irq_pending ? req_idx : '0;
endmodule

// File: rtl/vit_tracker_chk.sv
module vit_tracker_chk #(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               raise_vld,
  input logic [VEC_W-1:0]   raise_vec,
  input logic               ack_vld,
  input logic [VEC_W-1:0]   ack_vec,
  input logic               eoi,
  input logic [NUM_VEC-1:0] req,
  input logic [NUM_VEC-1:0] isr,
  input logic [NUM_VEC-1:0] en,
  input logic               irq_pending,
  input logic [VEC_W-1:0]   irq_vector
);
  p_coalesce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && req[raise_vec] && !ack_vld) |=> $stable(req));

  p_drop_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && !en[raise_vec] && !req[raise_vec]) |=> !req[$past(raise_vec)]);

  p_pending_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req[irq_vector] && !isr[irq_vector]));

  p_idle_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |-> (irq_vector == '0));

  p_ack_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !(raise_vld && raise_vec == ack_vec))
      |=> (isr[$past(ack_vec)] && !req[$past(ack_vec)]));

  p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_vld && (|isr)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && raise_vld && raise_vec == ack_vec && en[raise_vec])
      |=> (req[$past(raise_vec)] && isr[$past(raise_vec)]));
endmodule

bind vit_tracker vit_tracker_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .raise_vld(raise_vld), .raise_vec(raise_vec),
  .ack_vld(ack_vld), .ack_vec(ack_vec), .eoi(eoi),
  .req(req_q), .isr(isr_q), .en(en_q),
  .irq_pending(irq_pending), .irq_vector(irq_vector)
);

// File: tb/vit_tracker_tb_top.sv
module vit_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        raise_vld, ack_vld, eoi, reg_wr;
  logic [7:0]  raise_vec, ack_vec;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_pending;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  vit_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_vec(raise_vec),
    .ack_vld(ack_vld), .ack_vec(ack_vec), .eoi(eoi),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pending(irq_pending), .irq_vector(irq_vector)
  );

  // Monitor: compares queued expectations after outputs settle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {23'd0, irq_pending, irq_vector} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_irq(input bit p, input logic [7:0] v, input string tag);
    item_t it;
    it.is_irq = 1; it.addr = '0; it.exp = {23'd0, p, v}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic do_raise(input logic [7:0] v);
    raise_vld = 1; raise_vec = v; @(negedge clk); raise_vld = 0;
  endtask

  task automatic do_ack(input logic [7:0] v);
    ack_vld = 1; ack_vec = v; @(negedge clk); ack_vld = 0;
  endtask

  task automatic do_both(input logic [7:0] v);
    raise_vld = 1; raise_vec = v; ack_vld = 1; ack_vec = v;
    @(negedge clk); raise_vld = 0; ack_vld = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; @(negedge clk); eoi = 0;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; raise_vld = 0; ack_vld = 0; eoi = 0; reg_wr = 0;
    raise_vec = 0; ack_vec = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    exp_irq(0, 8'd0, "R1 pending after reset");
    exp_rd(12'h480, 32'hFFFF_FFFF, "R1 enable word0 reset");
    exp_rd(12'h4F0, 32'hFFFF_FFFF, "R1 enable word7 reset");
    exp_rd(12'h200, 32'h0, "R1 request word0 reset");
    exp_rd(12'h170, 32'h0, "R1 in-service word7 reset");

    do_raise(8'd5);
    exp_rd(12'h200, 32'h0000_0020, "R2 raise 5 sets bit5 word0");
    exp_irq(1, 8'd5, "R5 pending with empty in-service");

    do_raise(8'd5);
    do_raise(8'd40);
    exp_rd(12'h200, 32'h0000_0020, "R3 repeated raise coalesces");
    exp_rd(12'h210, 32'h0000_0100, "R9 vector 40 in word1 bit8");
    exp_irq(1, 8'd40, "R6 higher vector wins");

    do_ack(8'd40);
    exp_rd(12'h110, 32'h0000_0100, "R7 ack sets in-service 40");
    exp_rd(12'h210, 32'h0, "R7 ack clears request 40");
    exp_irq(0, 8'd0, "R5 lower request blocked by in-service");

    do_raise(8'd200);
    exp_rd(12'h260, 32'h0000_0100, "R9 vector 200 in word6 bit8");
    exp_irq(1, 8'd200, "R5 higher request nests");

    do_ack(8'd200);
    do_eoi();
    exp_rd(12'h160, 32'h0, "R8 eoi retires highest (200)");
    exp_rd(12'h110, 32'h0000_0100, "R8 eoi keeps lower (40)");
    exp_irq(0, 8'd0, "R5 still blocked by 40");

    do_eoi();
    exp_irq(1, 8'd5, "R8 second eoi releases 5");
    do_eoi();
    exp_irq(1, 8'd5, "R8 eoi with empty in-service is no-op");
    exp_rd(12'h200, 32'h0000_0020, "R8 no-op eoi keeps request");

    do_wr(12'h4A0, 32'h0);
    exp_rd(12'h4A0, 32'h0, "R10 enable word2 written");
    do_raise(8'd70);
    exp_rd(12'h220, 32'h0, "R4 disabled vector 70 dropped");
    exp_irq(1, 8'd5, "R4 pending unchanged by dropped raise");
    do_wr(12'h200, 32'h0);
    do_wr(12'h100, 32'hFFFF_FFFF);
    exp_rd(12'h200, 32'h0000_0020, "R10 request word not writable");
    exp_rd(12'h100, 32'h0, "R10 in-service word not writable");
    exp_rd(12'h300, 32'h0, "R9 unmapped address reads 0");

    do_both(8'd5);
    exp_rd(12'h200, 32'h0000_0020, "R11 same-cycle raise re-sets request");
    exp_rd(12'h100, 32'h0000_0020, "R11 same-cycle ack sets in-service");
    exp_irq(0, 8'd0, "R5 equal vectors not pending");

    do_raise(8'd255);
    exp_rd(12'h270, 32'h8000_0000, "R9 vector 255 in word7 bit31");
    exp_irq(1, 8'd255, "R6 top vector delivered");
    do_ack(8'd255);
    do_eoi();
    exp_rd(12'h170, 32'h0, "R8 eoi retires 255");
    do_eoi();
    exp_irq(1, 8'd5, "R8 after all eoi vector 5 pending");

    do_ack(8'd5);
    do_eoi();
    exp_irq(0, 8'd0, "R6 idle vector is 0");
    do_raise(8'd0);
    exp_rd(12'h200, 32'h0000_0001, "R2 vector 0 in word0 bit0");
    exp_irq(1, 8'd0, "R5 vector 0 above empty in-service");

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule